// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing mode of an 8-bit microcontroller instruction into the 16-bit address of its memory operand. The decoder pulses `start` with a mode code, the one or two operand bytes that follow the opcode, the two index registers and the direct-page select flag. For the direct-page and absolute families the address is pure arithmetic and appears one cycle later. The direct-page base is 0x0000 or 0x0100, chosen by the flag. The two pointer modes need a 16-bit pointer from memory. For these the block runs two back-to-back byte reads on a single-cycle-latency read port, then returns the assembled address. Immediate operands have no address; for them the block answers at once with a flag that says so.

The two pointer modes differ in where the index goes. The pre-indexed mode adds X to the direct-page address before the pointer is read. The post-indexed mode reads the pointer at the plain direct-page address and adds Y to the full 16-bit pointer afterwards. All sums wrap at 16 bits.

Top module: `operand_ea_gen`

## Requirements
- R1: While reset is low, and in the first cycle after it, `done` and `rd_req` are low.
- R2: Mode 0 (immediate) and the unused codes 9 to 15 give a `done` pulse one cycle after `start`, with `no_addr` = 1, `ea` = 0 and no read request; every other mode gives `no_addr` = 0.
- R3: Mode 1 (direct page) gives `ea` = `dp_sel`*256 + `opnd_lo`.
- R4: Mode 2 gives `dp_sel`*256 + `opnd_lo` + `idx_x`, and mode 3 gives the same sum with `idx_y` in place of `idx_x`, with no 8-bit wrap of the sum.
- R5: Mode 6 gives `ea` = `opnd_hi`*256 + `opnd_lo`; modes 7 and 8 add `idx_x` or `idx_y` to it, modulo 65536.
- R6: Mode 4 reads the pointer low byte at D = `dp_sel`*256 + `opnd_lo` + `idx_x` and the high byte at D+1 (mod 65536); `ea` = high*256 + low.
- R7: Mode 5 reads the low byte at `dp_sel`*256 + `opnd_lo` and the high byte at that address plus one; `ea` = (high*256 + low + `idx_y`) mod 65536.
- R8: For modes 4 and 5, `rd_req` is high in exactly the first and second cycles after `start`. It carries the low-byte address first and then the high-byte address. Read data is taken in the cycle after each request, and `done` is high in the fourth cycle after `start`. The modes 0 to 3 and 6 to 8 and the codes 9 to 15 make no read request and finish in the first cycle.
- R9: A `start` in the three cycles after a pointer-mode `start` is ignored: the pending result, its read addresses and its single `done` pulse are unchanged, and no extra `done` follows.
- R10: `done` is a one-cycle pulse, and a `start` given in the cycle where `done` is high is accepted as a new request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse; inputs below are sampled with it |
| mode | input | 4 | Addressing mode code (see R2 to R7) |
| opnd_lo | input | 8 | First operand byte (offset or address low byte) |
| opnd_hi | input | 8 | Second operand byte (absolute address high byte) |
| idx_x | input | 8 | X index register |
| idx_y | input | 8 | Y index register |
| dp_sel | input | 1 | Direct-page select flag, base = flag*256 |
| rd_req | output | 1 | Pointer byte read request |
| rd_addr | output | 16 | Pointer byte read address |
| rd_data | input | 8 | Read data, valid the cycle after `rd_req` |
| done | output | 1 | Result valid pulse |
| ea | output | 16 | Effective address |
| no_addr | output | 1 | Operand has no memory address (immediate or unused code) |

## Verification
A new request can be accepted in the same cycle that the previous result's `done` is high. A `start` can also arrive while a pointer fetch is still running. The bench provokes the first case by issuing every request of the sweep on the very cycle the previous `done` is seen. It provokes the second by driving `start` with a different mode, operand and index values in each busy cycle of a pointer fetch. In both cases the result is judged against the arithmetic value of the original request, together with its read address sequence, its latency and a single `done` pulse.

// File: rtl/oag_pkg.sv
// Package: shared mode codes and helpers for the operand address generator.
// Assumes a 4-bit mode field; codes above AM_ABSY are treated as "no address".
package oag_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [MODE_W-1:0] {
        AM_IMM     = 4'd0,
        AM_DP      = 4'd1,
        AM_DPX     = 4'd2,
        AM_DPY     = 4'd3,
        AM_PRE_IND = 4'd4,
        AM_POST_IND= 4'd5,
        AM_ABS     = 4'd6,
        AM_ABSX    = 4'd7,
        AM_ABSY    = 4'd8
    } amode_e;

    // True for the two modes that fetch a pointer from memory.
    function automatic logic is_ptr_mode(input logic [MODE_W-1:0] m);
        return (m == AM_PRE_IND) || (m == AM_POST_IND);
    endfunction

endpackage

// File: rtl/oag_addr_calc.sv
// Module: oag_addr_calc
// Purely combinational address arithmetic for every mode. It produces the
// final address of the non-pointer modes, the pointer location of the pointer
// modes and the index that must be added after the pointer is read.
// Assumes the address is exactly two data bytes wide; sums wrap at that width.
module oag_addr_calc
    import oag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [MODE_W-1:0]   mode,
    input  logic [DATA_W-1:0]   opnd_lo,
    input  logic [DATA_W-1:0]   opnd_hi,
    input  logic [DATA_W-1:0]   idx_x,
    input  logic [DATA_W-1:0]   idx_y,
    input  logic                dp_sel,
    output logic [2*DATA_W-1:0] direct_ea,
    output logic [2*DATA_W-1:0] ptr_loc,
    output logic [DATA_W-1:0]   post_idx,
    output logic                no_addr,
    output logic                ptr_mode
);

    localparam int ADDR_W = 2 * DATA_W;

    logic [ADDR_W-1:0] page_base;
    logic [ADDR_W-1:0] ext_lo;
    logic [ADDR_W-1:0] ext_x;
    logic [ADDR_W-1:0] ext_y;
    logic [ADDR_W-1:0] dp_addr;
    logic [ADDR_W-1:0] abs_addr;

    // Zero-extend the bytes and place the page flag just above the offset.
    always_comb begin
        page_base = {{(DATA_W-1){1'b0}}, dp_sel, {DATA_W{1'b0}}};
        ext_lo    = {{DATA_W{1'b0}}, opnd_lo};
        ext_x     = {{DATA_W{1'b0}}, idx_x};
        ext_y     = {{DATA_W{1'b0}}, idx_y};
        dp_addr   = page_base + ext_lo;
        abs_addr  = {opnd_hi, opnd_lo};
    end

    // Select the per-mode address and the pointer location.
    always_comb begin
        direct_ea = '0;
        ptr_loc   = dp_addr;
        post_idx  = '0;
        no_addr   = 1'b0;
        ptr_mode  = is_ptr_mode(mode);
        case (mode)
            AM_DP:       direct_ea = dp_addr;
            AM_DPX:      direct_ea = dp_addr + ext_x;
            AM_DPY:      direct_ea = dp_addr + ext_y;
            AM_ABS:      direct_ea = abs_addr;
            AM_ABSX:     direct_ea = abs_addr + ext_x;
            AM_ABSY:     direct_ea = abs_addr + ext_y;
            AM_PRE_IND:  ptr_loc   = dp_addr + ext_x;
            AM_POST_IND: post_idx  = idx_y;
            default:     no_addr   = 1'b1;
        endcase
    end

endmodule

// File: rtl/oag_ptr_fetch.sv
// Module: oag_ptr_fetch
// Two-read sequencer that fetches a little-endian pointer from a byte-wide
// port and adds a post index. One request per cycle; data arrives the cycle
// after its request. Result is presented combinationally in the FIN state.
module oag_ptr_fetch #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                launch,
    input  logic [2*DATA_W-1:0] ptr_loc,
    input  logic [DATA_W-1:0]   post_idx,
    output logic                rd_req,
    output logic [2*DATA_W-1:0] rd_addr,
    input  logic [DATA_W-1:0]   rd_data,
    output logic                busy,
    output logic                fin,
    output logic [2*DATA_W-1:0] ptr_ea
);

    localparam int ADDR_W = 2 * DATA_W;

    typedef enum logic [1:0] {PF_IDLE, PF_RD_LO, PF_RD_HI, PF_FIN} pf_state_e;

    pf_state_e         state_q;
    logic [ADDR_W-1:0] loc_q;
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] lo_q;

    // Sequence the two reads and the final assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PF_IDLE;
            loc_q   <= '0;
            idx_q   <= '0;
            lo_q    <= '0;
        end else begin
            case (state_q)
                PF_IDLE: if (launch) begin
                    loc_q   <= ptr_loc;
                    idx_q   <= post_idx;
                    state_q <= PF_RD_LO;
                end
                PF_RD_LO: state_q <= PF_RD_HI;
                PF_RD_HI: begin
                    lo_q    <= rd_data;
                    state_q <= PF_FIN;
                end
                default: state_q <= PF_IDLE;
            endcase
        end
    end

    // Drive the read port from the current state.
    always_comb begin
        rd_req  = (state_q == PF_RD_LO) || (state_q == PF_RD_HI);
        rd_addr = (state_q == PF_RD_HI) ? loc_q + ADDR_W'(1) : loc_q;
    end

    // Assemble the pointer from the returning high byte and add the index.
    always_comb begin
        busy   = (state_q != PF_IDLE);
        fin    = (state_q == PF_FIN);
        ptr_ea = {rd_data, lo_q} + {{DATA_W{1'b0}}, idx_q};
    end

endmodule

// File: rtl/operand_ea_gen.sv
// Module: operand_ea_gen (top)
// Accepts a request when idle, computes arithmetic modes in one cycle and
// hands pointer modes to the fetch sequencer. Registers done/ea/no_addr.
// Assumes start is ignored while a pointer fetch is running.
module operand_ea_gen
    import oag_pkg::*;
#(
    parameter int DATA_W = 8,
    localparam int ADDR_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [DATA_W-1:0] opnd_lo,
    input  logic [DATA_W-1:0] opnd_hi,
    input  logic [DATA_W-1:0] idx_x,
    input  logic [DATA_W-1:0] idx_y,
    input  logic              dp_sel,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic [ADDR_W-1:0] ea,
    output logic              no_addr
);

    logic [ADDR_W-1:0] direct_ea;
    logic [ADDR_W-1:0] ptr_loc;
    logic [DATA_W-1:0] post_idx;
    logic              calc_no_addr;
    logic              ptr_mode;
    logic              busy;
    logic              fin;
    logic [ADDR_W-1:0] ptr_ea;
    logic              accept;
    logic              done_q;
    logic [ADDR_W-1:0] ea_q;
    logic              no_addr_q;

    oag_addr_calc #(.DATA_W(DATA_W)) u_calc (
        .mode      (mode),
        .opnd_lo   (opnd_lo),
        .opnd_hi   (opnd_hi),
        .idx_x     (idx_x),
        .idx_y     (idx_y),
        .dp_sel    (dp_sel),
        .direct_ea (direct_ea),
        .ptr_loc   (ptr_loc),
        .post_idx  (post_idx),
        .no_addr   (calc_no_addr),
        .ptr_mode  (ptr_mode)
    );

    // A request is taken only when no pointer fetch is pending.
    always_comb accept = start && !busy;

    oag_ptr_fetch #(.DATA_W(DATA_W)) u_fetch (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (accept && ptr_mode),
        .ptr_loc  (ptr_loc),
        .post_idx (post_idx),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .busy     (busy),
        .fin      (fin),
        .ptr_ea   (ptr_ea)
    );

    // Register the result of whichever path finishes this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q    <= 1'b0;
            ea_q      <= '0;
            no_addr_q <= 1'b0;
        end else begin
            done_q <= fin || (accept && !ptr_mode);
            if (fin) begin
                ea_q      <= ptr_ea;
                no_addr_q <= 1'b0;
            end else if (accept && !ptr_mode) begin
                ea_q      <= direct_ea;
                no_addr_q <= calc_no_addr;
            end
        end
    end

    // Present the registered result.
    always_comb begin
        done    = done_q;
        ea      = ea_q;
        no_addr = no_addr_q;
    end

endmodule

// File: rtl/oag_checker.sv
// Module: oag_checker
// Port-level protocol checks for operand_ea_gen. Keeps its own model of the
// busy window (three cycles after an accepted pointer-mode start).
module oag_checker
    import oag_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [MODE_W-1:0]   mode,
    input logic                rd_req,
    input logic [2*DATA_W-1:0] rd_addr,
    input logic                done,
    input logic [2*DATA_W-1:0] ea,
    input logic                no_addr
);

    logic [1:0] win_q;
    logic       taken;
    logic       ptr_m;

    always_comb begin
        taken = start && (win_q == 2'd0);
        ptr_m = is_ptr_mode(mode);
    end

    // Track the busy window of a pointer fetch.
    always_ff @(posedge clk) begin
        if (!rst_n)                win_q <= 2'd0;
        else if (taken && ptr_m)   win_q <= 2'd3;
        else if (win_q != 2'd0)    win_q <= win_q - 2'd1;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!done && !rd_req)); // R1
    AST_NOADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_addr) |-> (ea == '0)); // R2
    AST_DIRECT_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && !ptr_m) |=> (done && !rd_req)); // R8
    AST_PTR_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
        (taken && ptr_m) |=> rd_req ##1 rd_req ##1 !rd_req ##1 done); // R8
    AST_REQ_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> (win_q == 2'd3 || win_q == 2'd2)); // R8
    AST_HI_FOLLOWS_LO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && win_q == 2'd2) |-> (rd_addr == $past(rd_addr) + 1'b1)); // R6
    AST_NO_DONE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q != 2'd0) |-> !done); // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done); // R10

endmodule

bind operand_ea_gen oag_checker #(.DATA_W(DATA_W)) u_oag_checker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .mode    (mode),
    .rd_req  (rd_req),
    .rd_addr (rd_addr),
    .done    (done),
    .ea      (ea),
    .no_addr (no_addr)
);

// File: tb/test_operand_ea_gen.sv
// Bench: sweeps every mode code over a grid of operands, indices and page
// flags, with an arithmetic memory model and interfering starts.
module test_operand_ea_gen;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = '0;
    logic [7:0]  opnd_lo = '0, opnd_hi = '0, idx_x = '0, idx_y = '0;
    logic        dp_sel = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data = '0;
    logic        done;
    logic [15:0] ea;
    logic        no_addr;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    operand_ea_gen i_operand_ea_gen (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .dp_sel(dp_sel), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
        .done(done), .ea(ea), .no_addr(no_addr)
    );

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[10:8], a[15:11]} ^ 8'h5A;
    endfunction

    // Memory model: one cycle read latency.
    always @(posedge clk) if (rd_req) rd_data <= mem_byte(rd_addr);

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // Watchdog: an expired run counts as a failed check.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 190000 && !finished) begin
                n_chk++; n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", cycles, 190000);
                summary();
            end
        end
    end

    // Run one request; start is driven at the current negedge.
    task automatic run_op(input logic [3:0] m, input logic [7:0] lo, input logic [7:0] hi,
                          input logic [7:0] x, input logic [7:0] y, input logic p,
                          input bit inject);
        logic [15:0] dp, loc, exp_ea, a0, a1;
        logic        exp_na, ptr;
        int          lat, nreq, exp_lat;
        string       rq;
        dp = {7'd0, p, 8'd0} + {8'd0, lo};
        exp_na = 1'b0; ptr = 1'b0; loc = dp; exp_ea = '0; rq = "R3";
        case (m)
            4'd1: begin exp_ea = dp; rq = "R3"; end
            4'd2: begin exp_ea = dp + {8'd0, x}; rq = "R4"; end
            4'd3: begin exp_ea = dp + {8'd0, y}; rq = "R4"; end
            4'd4: begin ptr = 1; loc = dp + {8'd0, x};
                  exp_ea = {mem_byte(loc + 16'd1), mem_byte(loc)}; rq = "R6"; end
            4'd5: begin ptr = 1; loc = dp;
                  exp_ea = {mem_byte(loc + 16'd1), mem_byte(loc)} + {8'd0, y}; rq = "R7"; end
            4'd6: begin exp_ea = {hi, lo}; rq = "R5"; end
            4'd7: begin exp_ea = {hi, lo} + {8'd0, x}; rq = "R5"; end
            4'd8: begin exp_ea = {hi, lo} + {8'd0, y}; rq = "R5"; end
            default: begin exp_na = 1'b1; rq = "R2"; end
        endcase
        exp_lat = ptr ? 4 : 1;
        mode = m; opnd_lo = lo; opnd_hi = hi; idx_x = x; idx_y = y; dp_sel = p;
        start = 1'b1;
        lat = 0; nreq = 0; a0 = '0; a1 = '0;
        forever begin
            @(negedge clk);
            lat++;
            if (inject && lat < 4) begin
                start = 1'b1; mode = 4'd6; opnd_lo = ~lo; opnd_hi = ~hi;
                idx_x = x + 8'd3; idx_y = y + 8'd5; dp_sel = ~p;   // R9 interference
            end else begin
                start = 1'b0;
            end
            if (rd_req) begin
                if (nreq == 0) a0 = rd_addr; else a1 = rd_addr;
                nreq++;
            end
            if (done || lat > 12) break;
        end
        chk(done, "R8", "done seen", 32'(done), 1);
        chk(lat == exp_lat, "R8", "latency", lat, exp_lat);
        chk(nreq == (ptr ? 2 : 0), "R8", "read count", nreq, ptr ? 2 : 0);
        chk(ea == exp_ea, rq, "ea", ea, exp_ea);
        chk(no_addr == exp_na, "R2", "no_addr", 32'(no_addr), 32'(exp_na));
        if (ptr) begin
            chk(a0 == loc, rq, "low-byte read address", a0, loc);
            chk(a1 == loc + 16'd1, rq, "high-byte read address", a1, loc + 16'd1);
        end
        if (inject) begin
            @(negedge clk);
            chk(!done, "R9", "no extra done after ignored starts", 32'(done), 0);
            chk(ea == exp_ea, "R9", "ea kept", ea, exp_ea);
        end
    endtask

    initial begin
        logic [7:0] lov [3] = '{8'h00, 8'h7F, 8'hFF};
        logic [7:0] hiv [3] = '{8'h00, 8'h12, 8'hFF};
        logic [7:0] xv  [3] = '{8'h00, 8'h01, 8'hFF};
        logic [7:0] yv  [3] = '{8'h00, 8'h80, 8'hFF};
        repeat (3) @(negedge clk);
        chk(!done && !rd_req, "R1", "quiet in reset", {done, rd_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !rd_req, "R1", "quiet after reset", {done, rd_req}, 0);
        // Back-to-back sweep: each request starts in the cycle its predecessor's done is seen (R10).
        for (int m = 0; m < 16; m++)
            for (int p = 0; p < 2; p++)
                for (int a = 0; a < 3; a++)
                    for (int b = 0; b < 3; b++)
                        for (int i = 0; i < 3; i++)
                            for (int j = 0; j < 3; j++)
                                run_op(4'(m), lov[a], hiv[b], xv[i], yv[j], 1'(p), 1'b0);
        // Interfering starts during pointer fetches.
        for (int m = 4; m < 6; m++)
            for (int p = 0; p < 2; p++)
                for (int a = 0; a < 3; a++)
                    for (int i = 0; i < 3; i++)
                        run_op(4'(m), lov[a], 8'h34, xv[i], yv[i], 1'(p), 1'b1);
        // Done is a single-cycle pulse when no new start follows.
        run_op(4'd1, 8'h20, 8'h00, 8'h00, 8'h00, 1'b1, 1'b0);
        @(negedge clk);
        chk(!done, "R10", "done one cycle wide", 32'(done), 0);
        finished = 1'b1;
        summary();
    end

endmodule